// File: doc/BRIEF.md
# Latched Multiplexed-Pin NAND Sequencer

This block runs a raw 8-bit NAND flash device through sixteen general-purpose pins, where several pins do two jobs. Pins 13 to 15 carry the upper three data bits during a transfer. Between transfers they carry the chip-enable, command-latch and address-latch levels, and an external transparent latch holds those levels. Pin 11 opens that latch. One strobe pin (pin 12) acts as write-enable or as read-enable. Which of the two it acts as depends on a mode level on pin 3, which the external latch also holds.

The host issues one request at a time. A request is a control change (with an optional command byte), a byte write, or a byte read. The block then drives the pin values, output enables and strobe in the required order. It returns a read byte together with a one-cycle done pulse. Between transfers it reports the device ready line from pin 4. The strobe low and high phases each last a programmable number of clocks, with a floor of two.

Top module: `nand_pin_seq`

## Requirements
- R1: After reset and whenever the block is idle, pin 11 (latch open) and pin 12 (strobe) are driven high, pin 13 (chip-enable, active low) is high, pins 14 and 15 (command/address latch) and pin 3 (read mode) are low, and busy is low.
- R2: In a byte write, byte bits 0..4 appear on pins 0..4 and bits 5..7 on pins 13..15, all driven as outputs. This pattern is present while the strobe is low and is still present when the strobe rises.
- R3: The strobe is never low while pin 11 is high. The control levels held by the external latch during a write are the levels set by the most recent control request.
- R4: The strobe stays low for exactly max(cfg_lo,2) cycles. In a write, the data pattern stays driven for exactly max(cfg_hi,2) cycles, counting from the cycle in which the strobe rises.
- R5: In a read, the latch holds read mode = 1 before the strobe falls, and pins 0..4 and 13..15 are inputs while the strobe is low. rd_byte is assembled from pin_i sampled on the last strobe-low cycle (pins 0..4 give bits 0..4, pins 13..15 give bits 5..7) and is valid with done.
- R6: After a read completes, the level held by the latch for read mode is 0 again.
- R7: In the cycle after done, pin_o and pin_oe equal the idle pattern of R1, with the current control levels on pins 13..15.
- R8: While idle, dev_ready follows pin_i[4] one cycle later (high = ready).
- R9: A request is accepted only when busy is low. req_valid while busy has no effect. busy rises the cycle after acceptance and falls together with the done pulse.
- R10: A control request with req_cmd_en set first updates the latched control levels and then writes req_byte once, as one request with one done pulse. Without req_cmd_en it makes no strobe activity. Operation codes on req_op are 0 = control, 1 = write, 2 = read.
- R11: done is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 0 control, 1 write, 2 read |
| req_sel | input | 1 | Select device (drives chip-enable low) |
| req_cle | input | 1 | Command latch level |
| req_ale | input | 1 | Address latch level |
| req_cmd_en | input | 1 | Control request carries a command byte |
| req_byte | input | 8 | Byte to write or command byte |
| cfg_lo | input | CW | Strobe low cycles (floor 2) |
| cfg_hi | input | CW | Strobe high cycles (floor 2) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Byte returned by a read |
| dev_ready | output | 1 | Device ready status |
| pin_i | input | 16 | Pin input levels |
| pin_o | output | 16 | Pin output levels |
| pin_oe | output | 16 | Pin output enables |

## Verification
The hardest case to reach from the ports is a request arriving while a transfer is in flight. The design must drop it without disturbing the transfer, which is visible only as the absence of an extra strobe or done. The bench pulses a write request in the middle of a read and then counts strobe edges and done pulses. A second hard case is the latched control state, because it exists only in the external latch. The bench models that latch from pin 11 and compares what it holds at each strobe with the control levels last requested. Random strobe timings include values below the floor of two, so the clamp is exercised.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
  localparam int NPINS    = 16;
  localparam int P_RDMODE = 3;
  localparam int P_RDY    = 4;
  localparam int P_LATCH  = 11;
  localparam int P_STROBE = 12;
  localparam int P_CEN    = 13;
  localparam int P_CLE    = 14;
  localparam int P_ALE    = 15;
  localparam int HI_SHIFT = 8;
  localparam logic [NPINS-1:0] DATA_MASK = 16'hE01F;
  localparam logic [NPINS-1:0] CTRL_OE   = 16'hF808;

  typedef enum logic [1:0] {OP_CTRL = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2} op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_MODE_ON, ST_LATCH_LO, ST_XFER_LO,
    ST_XFER_HI, ST_RESTORE, ST_LATCH_HI, ST_MODE_OFF
  } st_e;

  typedef struct packed {
    logic cen;
    logic cle;
    logic ale;
    logic rdm;
  } ctl_t;

  function automatic logic [NPINS-1:0] byte_to_pins(input logic [7:0] b);
    logic [NPINS-1:0] p;
    p = '0;
    p[4:0] = b[4:0];
    p[7+HI_SHIFT:5+HI_SHIFT] = b[7:5];
    return p;
  endfunction

  function automatic logic [7:0] pins_to_byte(input logic [NPINS-1:0] p);
    return {p[7+HI_SHIFT:5+HI_SHIFT], p[4:0]};
  endfunction
endpackage

// File: rtl/nsq_phase_timer.sv
module nsq_phase_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= len - CW'(1);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/nsq_pin_drive.sv
module nsq_pin_drive
  import nsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  st_e              state,
  input  logic             is_read,
  input  logic [7:0]       wbyte,
  input  ctl_t             ctl,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe
);
  logic [NPINS-1:0] idle_o, nxt_o, nxt_oe;
  logic             latch_lvl;

  always_comb begin
    latch_lvl = !(state inside {ST_LATCH_LO, ST_XFER_LO, ST_XFER_HI, ST_RESTORE});
    idle_o = '0;
    idle_o[P_LATCH]  = latch_lvl;
    idle_o[P_STROBE] = 1'b1;
    idle_o[P_CEN]    = ctl.cen;
    idle_o[P_CLE]    = ctl.cle;
    idle_o[P_ALE]    = ctl.ale;
    idle_o[P_RDMODE] = ctl.rdm;
    nxt_o  = idle_o;
    nxt_oe = CTRL_OE;
    if (state inside {ST_XFER_LO, ST_XFER_HI}) begin
      nxt_oe = '0;
      nxt_oe[P_LATCH]  = 1'b1;
      nxt_oe[P_STROBE] = 1'b1;
      nxt_o = '0;
      nxt_o[P_STROBE] = (state == ST_XFER_HI);
      if (!is_read) begin
        nxt_oe = nxt_oe | DATA_MASK;
        nxt_o  = nxt_o | byte_to_pins(wbyte);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o  <= (NPINS'(1) << P_LATCH) | (NPINS'(1) << P_STROBE) | (NPINS'(1) << P_CEN);
      pin_oe <= CTRL_OE;
    end else begin
      pin_o  <= nxt_o;
      pin_oe <= nxt_oe;
    end
  end
endmodule

// File: rtl/nand_pin_seq.sv
module nand_pin_seq
  import nsq_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_sel,
  input  logic          req_cle,
  input  logic          req_ale,
  input  logic          req_cmd_en,
  input  logic [7:0]    req_byte,
  input  logic [CW-1:0] cfg_lo,
  input  logic [CW-1:0] cfg_hi,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rd_byte,
  output logic          dev_ready,
  input  logic [15:0]   pin_i,
  output logic [15:0]   pin_o,
  output logic [15:0]   pin_oe
);
  localparam logic [CW-1:0] MIN_PH = CW'(2);

  st_e           state, nxt;
  ctl_t          ctl_q;
  logic          rd_q, cmd_q, samp_pend, t_load, t_last, accept, fin;
  logic [7:0]    byte_q;
  logic [CW-1:0] lo_q, hi_q, t_len;

  assign accept = req_valid && (state == ST_IDLE) &&
                  (req_op inside {OP_CTRL, OP_WRITE, OP_READ});

  always_comb begin
    nxt = state;
    fin = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        case (req_op)
          OP_CTRL:  nxt = ST_CTRL;
          OP_WRITE: nxt = ST_LATCH_LO;
          default:  nxt = ST_MODE_ON;
        endcase
      end
      ST_CTRL:     begin nxt = cmd_q ? ST_LATCH_LO : ST_IDLE; fin = !cmd_q; end
      ST_MODE_ON:  nxt = ST_LATCH_LO;
      ST_LATCH_LO: nxt = ST_XFER_LO;
      ST_XFER_LO:  if (t_last) nxt = ST_XFER_HI;
      ST_XFER_HI:  if (t_last) nxt = ST_RESTORE;
      ST_RESTORE:  nxt = ST_LATCH_HI;
      ST_LATCH_HI: begin nxt = rd_q ? ST_MODE_OFF : ST_IDLE; fin = !rd_q; end
      ST_MODE_OFF: begin nxt = ST_IDLE; fin = 1'b1; end
      default:     nxt = ST_IDLE;
    endcase
  end

  assign t_load = (nxt != state) && (nxt inside {ST_XFER_LO, ST_XFER_HI});
  assign t_len  = (nxt == ST_XFER_LO) ? lo_q : hi_q;

  nsq_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .len(t_len), .last(t_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ctl_q     <= '{cen: 1'b1, cle: 1'b0, ale: 1'b0, rdm: 1'b0};
      rd_q      <= 1'b0;
      cmd_q     <= 1'b0;
      byte_q    <= '0;
      lo_q      <= MIN_PH;
      hi_q      <= MIN_PH;
      samp_pend <= 1'b0;
      done      <= 1'b0;
      rd_byte   <= '0;
      dev_ready <= 1'b0;
    end else begin
      state     <= nxt;
      done      <= fin;
      samp_pend <= (state == ST_XFER_LO) && t_last;
      if (accept) begin
        rd_q   <= (req_op == OP_READ);
        cmd_q  <= req_cmd_en;
        byte_q <= req_byte;
        lo_q   <= (cfg_lo < MIN_PH) ? MIN_PH : cfg_lo;
        hi_q   <= (cfg_hi < MIN_PH) ? MIN_PH : cfg_hi;
        if (req_op == OP_CTRL) begin
          ctl_q.cen <= !req_sel;
          ctl_q.cle <= req_cle;
          ctl_q.ale <= req_ale;
        end
        if (req_op == OP_READ) ctl_q.rdm <= 1'b1;
      end
      if (state == ST_LATCH_HI && nxt == ST_MODE_OFF) ctl_q.rdm <= 1'b0;
      if (samp_pend && rd_q) rd_byte <= pins_to_byte(pin_i);
      if (state == ST_IDLE) dev_ready <= pin_i[P_RDY];
    end
  end

  assign busy = (state != ST_IDLE);

  nsq_pin_drive u_drive (
    .clk(clk), .rst(rst), .state(state), .is_read(rd_q), .wbyte(byte_q),
    .ctl(ctl_q), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  AST_STROBE_UNDER_LATCH: assert property (@(posedge clk) disable iff (rst)
    !pin_o[P_STROBE] |-> !pin_o[P_LATCH]);                                   // R3
  AST_STROBE_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_o[P_STROBE]) |-> !$past(pin_o[P_STROBE], 2));                  // R4
  AST_READ_PINS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (!pin_o[P_STROBE] && rd_q) |-> ((pin_oe & DATA_MASK) == '0));            // R5
  AST_IDLE_LATCH_OPEN: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pin_o[P_LATCH] && pin_o[P_STROBE]));                          // R1
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);                                                   // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                         // R11
endmodule

// File: tb/sim_nand_pin_seq.sv
module sim_nand_pin_seq;
  localparam int CW = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_sel = 0, req_cle = 0, req_ale = 0, req_cmd_en = 0;
  logic [1:0] req_op = 0;
  logic [7:0] req_byte = 0;
  logic [CW-1:0] cfg_lo = 2, cfg_hi = 2;
  logic busy, done, dev_ready;
  logic [7:0] rd_byte;
  logic [15:0] pin_i, pin_o, pin_oe;

  always #2.5 clk = ~clk;

  nand_pin_seq #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_sel(req_sel),
    .req_cle(req_cle), .req_ale(req_ale), .req_cmd_en(req_cmd_en), .req_byte(req_byte),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .busy(busy), .done(done), .rd_byte(rd_byte),
    .dev_ready(dev_ready), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] spread(input logic [7:0] b);
    return {b[7:5], 8'h00, b[4:0]};
  endfunction
  function automatic logic [7:0] gather(input logic [15:0] p);
    return {p[15:13], p[4:0]};
  endfunction
  function automatic logic [15:0] idle_o(input logic cen, input logic cle, input logic ale);
    return {ale, cle, cen, 2'b11, 11'h000};
  endfunction

  // external latch and flash model
  logic lat_cen = 1, lat_cle = 0, lat_ale = 0, lat_rdm = 0;
  logic ready_lvl = 1;
  logic [7:0] flash_byte = 0;
  assign pin_i = (lat_rdm && !pin_o[12]) ? spread(flash_byte) : {11'h0, ready_lvl, 4'h0};

  logic prev_stb = 1, in_hold = 0;
  int lo_cnt = 0, last_lo = 0, hold_cnt = 0, wr_cnt = 0, done_cnt = 0, oe_bad = 0;
  int rdm_fall = 0;
  logic [7:0] wr_byte = 0;
  logic [2:0] wr_ctl = 0;

  always @(negedge clk) begin
    if (pin_o[11]) begin
      lat_cen <= pin_o[13]; lat_cle <= pin_o[14]; lat_ale <= pin_o[15]; lat_rdm <= pin_o[3];
    end
    if (prev_stb && !pin_o[12]) begin lo_cnt = 1; rdm_fall = lat_rdm; end
    else if (!pin_o[12]) lo_cnt++;
    if (!pin_o[12] && lat_rdm && ((pin_oe & 16'hE01F) != 0)) oe_bad++;
    if (in_hold) begin
      if (pin_oe[0] && pin_o[12]) hold_cnt++; else in_hold = 0;
    end
    if (!prev_stb && pin_o[12]) begin
      last_lo = lo_cnt;
      if (!lat_rdm) begin
        wr_cnt++; wr_byte = gather(pin_o); wr_ctl = {lat_cen, lat_cle, lat_ale};
        in_hold = 1; hold_cnt = pin_oe[0] ? 1 : 0;
      end
    end
    if (done) done_cnt++;
    prev_stb = pin_o[12];
  end

  logic e_cen = 1, e_cle = 0, e_ale = 0;
  bit timed_out = 0;

  task automatic wait_done();
    int n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    if (n >= 1000) begin timed_out = 1; chk(0, "R11 watchdog", 0, 1); end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic run(input int op, input bit sel, input bit cle, input bit ale,
                     input bit cmd, input logic [7:0] b, input int lo, input int hi,
                     input bit intrude);
    int elo, ehi;
    elo = (lo < 2) ? 2 : lo; ehi = (hi < 2) ? 2 : hi;
    wr_cnt = 0; done_cnt = 0; oe_bad = 0; last_lo = 0; hold_cnt = 0; rdm_fall = 0;
    if (op == 2) flash_byte = b;
    req_op = 2'(op); req_sel = sel; req_cle = cle; req_ale = ale; req_cmd_en = cmd;
    req_byte = b; cfg_lo = CW'(lo); cfg_hi = CW'(hi); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (intrude) begin
      @(negedge clk);
      chk(busy == 1, "R9 busy after accept", busy, 1);
      req_op = 2'd1; req_byte = ~b; req_valid = 1;
      @(negedge clk); req_valid = 0;
    end
    wait_done();
    if (op == 0) begin e_cen = !sel; e_cle = cle; e_ale = ale; end
    chk(done_cnt == 1, "R11 one done", done_cnt, 1);
    chk(pin_o == idle_o(e_cen, e_cle, e_ale), "R7 pins restored", pin_o, idle_o(e_cen, e_cle, e_ale));
    chk(pin_oe == 16'hF808, "R7 oe restored", pin_oe, 16'hF808);
    chk({lat_cen, lat_cle, lat_ale} == {e_cen, e_cle, e_ale}, "R3 latched ctl",
        {lat_cen, lat_cle, lat_ale}, {e_cen, e_cle, e_ale});
    if (op == 2) begin
      chk(rd_byte == b, "R5 read byte", rd_byte, b);
      chk(oe_bad == 0, "R5 pins input", oe_bad, 0);
      chk(rdm_fall == 1, "R5 read mode latched", rdm_fall, 1);
      chk(lat_rdm == 0, "R6 read mode cleared", lat_rdm, 0);
      chk(wr_cnt == 0, "R9 intrusion ignored", wr_cnt, 0);
      chk(last_lo == elo, "R4 low length", last_lo, elo);
    end else if (op == 1 || cmd) begin
      chk(wr_cnt == 1, (op == 0) ? "R10 one write" : "R2 one write", wr_cnt, 1);
      chk(wr_byte == b, (op == 0) ? "R10 cmd byte" : "R2 data", wr_byte, b);
      chk(wr_ctl == {e_cen, e_cle, e_ale}, "R3 ctl at strobe", wr_ctl, {e_cen, e_cle, e_ale});
      chk(last_lo == elo, "R4 low length", last_lo, elo);
      chk(hold_cnt == ehi, "R4 hold length", hold_cnt, ehi);
    end else begin
      chk(wr_cnt == 0 && last_lo == 0, "R10 no strobe", wr_cnt, 0);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(pin_o == idle_o(1, 0, 0), "R1 idle pins", pin_o, idle_o(1, 0, 0));
    chk(pin_oe == 16'hF808, "R1 idle oe", pin_oe, 16'hF808);
    chk(busy == 0, "R1 busy low", busy, 0);
    ready_lvl = 0; @(negedge clk); @(negedge clk);
    chk(dev_ready == 0, "R8 busy device", dev_ready, 0);
    ready_lvl = 1; @(negedge clk); @(negedge clk);
    chk(dev_ready == 1, "R8 ready device", dev_ready, 1);
    // directed corners
    run(0, 1, 0, 0, 0, 8'h00, 2, 2, 0);
    run(0, 1, 1, 0, 1, 8'hFF, 0, 1, 0);
    run(1, 0, 0, 0, 0, 8'hA5, 2, 2, 0);
    run(2, 0, 0, 0, 0, 8'h5A, 5, 3, 0);
    run(2, 0, 0, 0, 0, 8'hE0, 1, 0, 1);
    run(0, 1, 0, 1, 1, 8'h1F, 3, 7, 0);
    // random mix
    for (int i = 0; i < 60 && !timed_out; i++) begin
      int op;
      op = $urandom_range(0, 2);
      run(op, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          8'($urandom), $urandom_range(0, 6), $urandom_range(0, 6),
          (op == 2) && ($urandom_range(0, 3) == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule